// File: doc/BRIEF.md
# Three-Wire Serial Control Register File

This block is the slave side of a three-wire control port. A host reaches eight 9-bit control registers through a serial clock, an active-low frame strobe and a data line whose input and output halves are separate here. The registers are one mode word, one channel-select word, three 6-bit gain words and three 9-bit sign-magnitude offset words. Their fields drive the analog datapath directly through dedicated output ports.

All three serial inputs are resynchronised into the system clock domain. An edge detector then finds serial clock rises and falls. A framing state machine walks through the frame with these states:

- `S_IDLE`: waiting for the strobe to go low.
- `S_HDR`: shifting in the direction flag and the address.
- `S_SKIP`: passing over three ignored slots.
- `S_WDATA`: shifting in write data.
- `S_RDATA`: shifting read data out.
- `S_COMMIT`: a one-cycle write pulse.

The transitions are:

- IDLE to HDR when the strobe is low.
- HDR to SKIP on the fourth rise.
- SKIP to RDATA or WDATA on the seventh rise, according to the flag.
- WDATA to COMMIT when the strobe rises after exactly sixteen rises.
- WDATA to IDLE when the strobe rises after any other count.
- RDATA, HDR or SKIP to IDLE when the strobe rises.
- COMMIT to IDLE always.

The serial clock must run at one eighth of the system clock or slower.

Top module: `tri_wire_regfile`

## Requirements
- R1: A frame is bracketed by `load_n` low and carries 16 bits, MSB first, sampled on rising `sclk`. The bits are a direction flag (0 = write, 1 = read), address bits A2..A0, three ignored slots, then D8..D0. A write takes effect only after `load_n` returns high.
- R2: Address 0 is the mode word and address 1 is channel select. Addresses 2, 3 and 4 are the red, green and blue gains. Addresses 5, 6 and 7 are the red, green and blue offsets. A write changes only the addressed register.
- R3: The stored bits are D7..D2 of the mode word, D7..D4 of channel select, D5..D0 of each gain and all nine bits of each offset. Every other bit is stored as zero and reads back as zero.
- R4: After reset the mode word is 0x078, channel select is 0x0C0, and every gain and offset is 0.
- R5: In a read frame, `sdo_oe` is high during the data phase. `sdo` presents D8 first, and each following bit appears after a falling `sclk` edge, so the host samples on rising edges. A read changes no register, and `sdo_oe` is low outside the data phase.
- R6: A write frame with fewer or more than 16 rising `sclk` edges is discarded.
- R7: Setting the power-down bit (mode D2) leaves every other register unchanged, and registers stay readable and writable while it is set.
- R8: The field outputs are driven as follows. From the mode word: `fs_range_hi` = D7, `int_ref_en` = D6, `three_ch_en` = D5, `cds_en` = D4, `clamp_hi` = D3, `power_down` = D2. From channel select: `order_rgb` = D7, and `single_r`, `single_g`, `single_b` = D6, D5, D4. Each gain port carries D5..D0. Each offset port carries the 9-bit sign-magnitude word, with D8 as the sign.
- R9: The values in the three ignored slots have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| load_n | input | 1 | Active-low frame strobe |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the data line |
| fs_range_hi | output | 1 | Converter full-scale range select |
| int_ref_en | output | 1 | Internal reference enable |
| three_ch_en | output | 1 | Three-channel (1) or single-channel (0) |
| cds_en | output | 1 | Double-sampling (1) or sample-and-hold (0) |
| clamp_hi | output | 1 | Input clamp high (1) or low (0) level |
| power_down | output | 1 | Sleep request |
| order_rgb | output | 1 | Scan order red first (1) or blue first (0) |
| single_r | output | 1 | Single-channel red select |
| single_g | output | 1 | Single-channel green select |
| single_b | output | 1 | Single-channel blue select |
| gain_r | output | 6 | Red gain code |
| gain_g | output | 6 | Green gain code |
| gain_b | output | 6 | Blue gain code |
| offset_r | output | 9 | Red offset, sign-magnitude |
| offset_g | output | 9 | Green offset, sign-magnitude |
| offset_b | output | 9 | Blue offset, sign-magnitude |

## Verification
The bound assertions check on every cycle that:
- a commit pulse fires only for a write frame that counted exactly sixteen rises;
- registers change only in the cycle after that pulse, and a commit elsewhere leaves the mode word alone;
- reserved bits never hold a one;
- the output enable rises only at the start of a read's data phase.

Only the bench scenarios can show the rest: the bit order on `sdo`, the masking of reserved bits seen through read-back, the discarding of 15- and 17-bit frames, retention under power-down, and the mapping of each register field to its port. The bench does this by comparing all field ports against a behavioural register model on every clock.

// File: rtl/twr_pkg.sv
package twr_pkg;

    localparam int unsigned DATA_W    = 9;
    localparam int unsigned ADDR_W    = 3;
    localparam int unsigned SKIP_W    = 3;
    localparam int unsigned GAIN_W    = 6;
    localparam int unsigned NCOLOR    = 3;
    localparam int unsigned NREG      = 1 << ADDR_W;
    localparam int unsigned HDR_LEN   = 1 + ADDR_W;
    localparam int unsigned PRE_LEN   = HDR_LEN + SKIP_W;
    localparam int unsigned FRAME_LEN = PRE_LEN + DATA_W;
    localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);

    // mode word bit positions
    localparam int unsigned M_RANGE = 7;
    localparam int unsigned M_REF   = 6;
    localparam int unsigned M_3CH   = 5;
    localparam int unsigned M_CDS   = 4;
    localparam int unsigned M_CLAMP = 3;
    localparam int unsigned M_PD    = 2;
    // channel-select bit positions
    localparam int unsigned C_ORDER = 7;
    localparam int unsigned C_RED   = 6;
    localparam int unsigned C_GRN   = 5;
    localparam int unsigned C_BLU   = 4;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE  = 3'd0,
        A_CHSEL = 3'd1,
        A_GAINR = 3'd2,
        A_GAING = 3'd3,
        A_GAINB = 3'd4,
        A_OFSR  = 3'd5,
        A_OFSG  = 3'd6,
        A_OFSB  = 3'd7
    } reg_addr_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_SKIP,
        S_WDATA,
        S_RDATA,
        S_COMMIT
    } fsm_e;

    function automatic word_t keep_mask(addr_t a);
        word_t m;
        unique case (reg_addr_e'(a))
            A_MODE:  m = word_t'(9'h0FC);
            A_CHSEL: m = word_t'(9'h0F0);
            A_GAINR,
            A_GAING,
            A_GAINB: m = word_t'((1 << GAIN_W) - 1);
            default: m = '1;
        endcase
        return m;
    endfunction

    function automatic word_t reset_word(addr_t a);
        word_t v;
        v = '0;
        unique case (reg_addr_e'(a))
            A_MODE: begin
                v[M_REF]   = 1'b1;
                v[M_3CH]   = 1'b1;
                v[M_CDS]   = 1'b1;
                v[M_CLAMP] = 1'b1;
            end
            A_CHSEL: begin
                v[C_ORDER] = 1'b1;
                v[C_RED]   = 1'b1;
            end
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
    parameter int unsigned WIDTH     = 1,
    parameter int unsigned STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[0] <= RST_VAL;
                else        chain_q[0] <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/twr_frame_fsm.sv
module twr_frame_fsm
    import twr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_s,
    input  logic             load_n_s,
    input  logic             sdi_s,
    input  word_t            rd_word,
    output addr_t            rd_addr,
    output logic             wr_en,
    output addr_t            wr_addr,
    output word_t            wr_data,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             hdr_rw,
    output logic [CNT_W-1:0] bit_cnt
);

    localparam logic [CNT_W-1:0] C_HDR   = CNT_W'(HDR_LEN);
    localparam logic [CNT_W-1:0] C_PRE   = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(FRAME_LEN);
    localparam logic [CNT_W-1:0] C_SAT   = '1;

    fsm_e             state_q, state_d;
    logic             sclk_d1;
    logic             rise, fall;
    logic [CNT_W-1:0] cnt_q, cnt_inc;
    word_t            sh_q, sh_nx;
    word_t            rd_sh_q;
    logic             rw_q;
    addr_t            addr_q;
    logic             sdo_q;

    assign rise    = sclk_s & ~sclk_d1;
    assign fall    = ~sclk_s & sclk_d1;
    assign cnt_inc = (cnt_q == C_SAT) ? cnt_q : cnt_q + 1'b1;
    assign sh_nx   = {sh_q[DATA_W-2:0], sdi_s};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (!load_n_s) state_d = S_HDR;
            end
            S_HDR: begin
                if (load_n_s)                       state_d = S_IDLE;
                else if (rise && cnt_inc == C_HDR)  state_d = S_SKIP;
            end
            S_SKIP: begin
                if (load_n_s)                       state_d = S_IDLE;
                else if (rise && cnt_inc == C_PRE)  state_d = rw_q ? S_RDATA : S_WDATA;
            end
            S_WDATA: begin
                if (load_n_s) state_d = (cnt_q == C_FRAME) ? S_COMMIT : S_IDLE;
            end
            S_RDATA: begin
                if (load_n_s) state_d = S_IDLE;
            end
            S_COMMIT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d1 <= 1'b0;
            cnt_q   <= '0;
            sh_q    <= '0;
            rd_sh_q <= '0;
            rw_q    <= 1'b0;
            addr_q  <= '0;
            sdo_q   <= 1'b0;
        end else begin
            sclk_d1 <= sclk_s;
            unique case (state_q)
                S_IDLE: begin
                    cnt_q <= '0;
                    sdo_q <= 1'b0;
                end
                S_HDR, S_SKIP, S_WDATA, S_RDATA: begin
                    if (!load_n_s && rise) begin
                        cnt_q <= cnt_inc;
                        sh_q  <= sh_nx;
                        if (state_q == S_HDR && cnt_inc == C_HDR) begin
                            rw_q   <= sh_nx[ADDR_W];
                            addr_q <= sh_nx[ADDR_W-1:0];
                        end
                    end
                    if (state_q == S_SKIP && state_d == S_RDATA) begin
                        rd_sh_q <= rd_word;
                    end else if (state_q == S_RDATA && !load_n_s && fall) begin
                        sdo_q   <= rd_sh_q[DATA_W-1];
                        rd_sh_q <= {rd_sh_q[DATA_W-2:0], 1'b0};
                    end
                end
                S_COMMIT: begin
                    sdo_q <= 1'b0;
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign rd_addr = addr_q;
    assign wr_addr = addr_q;
    assign wr_data = sh_q;
    assign wr_en   = (state_q == S_COMMIT);
    assign sdo     = sdo_q;
    assign sdo_oe  = (state_q == S_RDATA);
    assign hdr_rw  = rw_q;
    assign bit_cnt = cnt_q;

endmodule

// File: rtl/twr_reg_bank.sv
module twr_reg_bank
    import twr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  addr_t                       wr_addr,
    input  word_t                       wr_data,
    input  addr_t                       rd_addr,
    output word_t                       rd_word,
    output logic [NREG-1:0][DATA_W-1:0] reg_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                reg_q[i] <= reset_word(addr_t'(i));
            end
        end else if (wr_en) begin
            reg_q[wr_addr] <= wr_data & keep_mask(wr_addr);
        end
    end

    assign rd_word = reg_q[rd_addr];

endmodule

// File: rtl/twr_field_decode.sv
module twr_field_decode
    import twr_pkg::*;
(
    input  logic [NREG-1:0][DATA_W-1:0]   reg_q,
    output logic                          fs_range_hi,
    output logic                          int_ref_en,
    output logic                          three_ch_en,
    output logic                          cds_en,
    output logic                          clamp_hi,
    output logic                          power_down,
    output logic                          order_rgb,
    output logic                          single_r,
    output logic                          single_g,
    output logic                          single_b,
    output logic [NCOLOR-1:0][GAIN_W-1:0] gain_arr,
    output logic [NCOLOR-1:0][DATA_W-1:0] ofs_arr
);

    word_t mode_w, chsel_w;
    logic  unused_rsvd;

    assign mode_w  = reg_q[A_MODE];
    assign chsel_w = reg_q[A_CHSEL];

    assign fs_range_hi = mode_w[M_RANGE];
    assign int_ref_en  = mode_w[M_REF];
    assign three_ch_en = mode_w[M_3CH];
    assign cds_en      = mode_w[M_CDS];
    assign clamp_hi    = mode_w[M_CLAMP];
    assign power_down  = mode_w[M_PD];
    assign order_rgb   = chsel_w[C_ORDER];
    assign single_r    = chsel_w[C_RED];
    assign single_g    = chsel_w[C_GRN];
    assign single_b    = chsel_w[C_BLU];

    generate
        for (genvar c = 0; c < NCOLOR; c++) begin : g_color
            assign gain_arr[c] = reg_q[int'(A_GAINR) + c][GAIN_W-1:0];
            assign ofs_arr[c]  = reg_q[int'(A_OFSR) + c];
        end
    endgenerate

    // reserved bit positions are held at zero by the bank and carry no field
    assign unused_rsvd = ^{mode_w[DATA_W-1], mode_w[1:0], chsel_w[DATA_W-1], chsel_w[3:0],
                           reg_q[A_GAINR][DATA_W-1:GAIN_W], reg_q[A_GAING][DATA_W-1:GAIN_W],
                           reg_q[A_GAINB][DATA_W-1:GAIN_W]};

endmodule

// File: rtl/tri_wire_regfile.sv
module tri_wire_regfile
    import twr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              load_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              fs_range_hi,
    output logic              int_ref_en,
    output logic              three_ch_en,
    output logic              cds_en,
    output logic              clamp_hi,
    output logic              power_down,
    output logic              order_rgb,
    output logic              single_r,
    output logic              single_g,
    output logic              single_b,
    output logic [GAIN_W-1:0] gain_r,
    output logic [GAIN_W-1:0] gain_g,
    output logic [GAIN_W-1:0] gain_b,
    output logic [DATA_W-1:0] offset_r,
    output logic [DATA_W-1:0] offset_g,
    output logic [DATA_W-1:0] offset_b
);

    logic                          sclk_s, load_n_s, sdi_s;
    logic                          wr_en;
    addr_t                         wr_addr, rd_addr;
    word_t                         wr_data, rd_word;
    logic                          hdr_rw;
    logic [CNT_W-1:0]              bit_cnt;
    logic [NREG-1:0][DATA_W-1:0]   reg_flat;
    logic [NCOLOR-1:0][GAIN_W-1:0] gain_arr;
    logic [NCOLOR-1:0][DATA_W-1:0] ofs_arr;

    twr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, load_n, sdi}),
        .q     ({sclk_s, load_n_s, sdi_s})
    );

    twr_frame_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .load_n_s (load_n_s),
        .sdi_s    (sdi_s),
        .rd_word  (rd_word),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe),
        .hdr_rw   (hdr_rw),
        .bit_cnt  (bit_cnt)
    );

    twr_reg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word),
        .reg_q   (reg_flat)
    );

    twr_field_decode u_dec (
        .reg_q       (reg_flat),
        .fs_range_hi (fs_range_hi),
        .int_ref_en  (int_ref_en),
        .three_ch_en (three_ch_en),
        .cds_en      (cds_en),
        .clamp_hi    (clamp_hi),
        .power_down  (power_down),
        .order_rgb   (order_rgb),
        .single_r    (single_r),
        .single_g    (single_g),
        .single_b    (single_b),
        .gain_arr    (gain_arr),
        .ofs_arr     (ofs_arr)
    );

    assign gain_r   = gain_arr[0];
    assign gain_g   = gain_arr[1];
    assign gain_b   = gain_arr[2];
    assign offset_r = ofs_arr[0];
    assign offset_g = ofs_arr[1];
    assign offset_b = ofs_arr[2];

endmodule

// File: rtl/twr_regfile_chk.sv
module twr_regfile_chk
    import twr_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic                        wr_en,
    input addr_t                       wr_addr,
    input logic                        hdr_rw,
    input logic [CNT_W-1:0]            bit_cnt,
    input logic                        sdo_oe,
    input logic [NREG-1:0][DATA_W-1:0] reg_flat
);

    // R6
    commit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> bit_cnt == CNT_W'(FRAME_LEN));

    // R1
    write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !hdr_rw);

    // R6
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_flat));

    // R2
    addr_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != A_MODE) |=> $stable(reg_flat[A_MODE]));

    // R5
    read_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (hdr_rw && bit_cnt == CNT_W'(PRE_LEN)));

    // R5
    read_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> !wr_en);

    generate
        for (genvar i = 0; i < NREG; i++) begin : g_rsvd
            // R3
            reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_flat[i] & ~keep_mask(addr_t'(i))) == '0);
        end
    endgenerate

endmodule

bind tri_wire_regfile twr_regfile_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .hdr_rw   (hdr_rw),
    .bit_cnt  (bit_cnt),
    .sdo_oe   (sdo_oe),
    .reg_flat (reg_flat)
);

// File: tb/tri_wire_regfile_tb.sv
`timescale 1ns/1ps
module tri_wire_regfile_tb;

    localparam int HALF = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, sclk = 1'b0, load_n = 1'b1, sdi = 1'b0;
    logic sdo, sdo_oe;
    logic fs_range_hi, int_ref_en, three_ch_en, cds_en, clamp_hi, power_down;
    logic order_rgb, single_r, single_g, single_b;
    logic [5:0] gain_r, gain_g, gain_b;
    logic [8:0] offset_r, offset_g, offset_b;

    int n_chk = 0;
    int n_fail = 0;
    int exp_reg[8];
    bit cmp_on = 1'b0;

    tri_wire_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .load_n(load_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe),
        .fs_range_hi(fs_range_hi), .int_ref_en(int_ref_en), .three_ch_en(three_ch_en),
        .cds_en(cds_en), .clamp_hi(clamp_hi), .power_down(power_down),
        .order_rgb(order_rgb), .single_r(single_r), .single_g(single_g), .single_b(single_b),
        .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b),
        .offset_r(offset_r), .offset_g(offset_g), .offset_b(offset_b)
    );

    function automatic int keep(int a);
        case (a)
            0:       return 'h0FC;
            1:       return 'h0F0;
            2, 3, 4: return 'h03F;
            default: return 'h1FF;
        endcase
    endfunction

    function automatic void model_reset();
        exp_reg = '{'h078, 'h0C0, 0, 0, 0, 0, 0, 0};
    endfunction

    function automatic logic [54:0] exp_fields();
        logic [8:0] m, c;
        m = exp_reg[0][8:0];
        c = exp_reg[1][8:0];
        return {m[7], m[6], m[5], m[4], m[3], m[2], c[7], c[6], c[5], c[4],
                exp_reg[2][5:0], exp_reg[3][5:0], exp_reg[4][5:0],
                exp_reg[5][8:0], exp_reg[6][8:0], exp_reg[7][8:0]};
    endfunction

    wire [54:0] act_fields = {fs_range_hi, int_ref_en, three_ch_en, cds_en, clamp_hi, power_down,
                              order_rgb, single_r, single_g, single_b,
                              gain_r, gain_g, gain_b, offset_r, offset_g, offset_b};

    task automatic chk(input string tag, input int got, input int expv);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, expv);
        end
    endtask

    // R8: every field port against the model on every clock
    always @(negedge clk) begin
        if (cmp_on) begin
            n_chk++;
            if (act_fields !== exp_fields()) begin
                n_fail++;
                $display("FAIL R8 field ports: actual %h expected %h at %0t",
                         act_fields, exp_fields(), $time);
            end
        end
    end

    task automatic frame(input bit rw, input int a, input int d, input int skip,
                         input int nbits, output int rd);
        logic [15:0] fr;
        int oe_bad;
        oe_bad = 0;
        rd = 0;
        fr = {rw, a[2:0], skip[2:0], d[8:0]};
        @(negedge clk);
        load_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 16) ? fr[15-i] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (rw && i >= 7 && i < 16) begin
                rd = (rd << 1) | int'(sdo);
                if (sdo_oe !== 1'b1) oe_bad++;
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cmp_on = 1'b0;
        load_n = 1'b1;
        sdi = 1'b0;
        repeat (8) @(negedge clk);
        if (!rw && nbits == 16) exp_reg[a] = d & keep(a);
        cmp_on = 1'b1;
        if (rw) chk("R5 sdo_oe high through data phase", oe_bad, 0);
        chk("R5 sdo_oe low after frame", int'(sdo_oe), 0);
    endtask

    task automatic wr(input int a, input int d);
        int dummy;
        frame(1'b0, a, d, 'b101, 16, dummy);
    endtask

    task automatic rd_chk(input string tag, input int a);
        int v;
        frame(1'b1, a, 0, 'b010, 16, v);
        chk(tag, v, exp_reg[a]);
    endtask

    initial begin
        #1ms;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        model_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cmp_on = 1'b1;

        // R4: reset state at the ports and through read-back
        chk("R4 int_ref_en default", int'(int_ref_en), 1);
        chk("R4 power_down default", int'(power_down), 0);
        chk("R4 single_r default", int'(single_r), 1);
        chk("R4 sdo_oe idle", int'(sdo_oe), 0);
        for (int a = 0; a < 8; a++) rd_chk("R4 default read-back", a);

        // R3: all-ones writes keep only the live bits
        for (int a = 0; a < 8; a++) begin
            wr(a, 'h1FF);
            rd_chk("R3 reserved bits read as zero", a);
        end

        // R2: distinct patterns land only at their own address
        for (int a = 0; a < 8; a++) wr(a, ('h155 ^ (a * 'h23)) & 'h1FF);
        for (int a = 0; a < 8; a++) rd_chk("R2 address map isolation", a);
        for (int a = 0; a < 8; a++) wr(a, 'h0AA);
        for (int a = 0; a < 8; a++) rd_chk("R1 alternate pattern MSB first", a);

        // R9: ignored slots
        begin
            int v;
            frame(1'b0, 2, 'h2A, 0, 16, v);
            rd_chk("R9 skip slots zero", 2);
            frame(1'b0, 2, 'h15, 7, 16, v);
            rd_chk("R9 skip slots ones", 2);
            chk("R9 gain_r port", int'(gain_r), 'h15);

            // R6: short and long frames are dropped
            frame(1'b0, 3, 'h3F, 5, 15, v);
            rd_chk("R6 short frame discarded", 3);
            chk("R6 gain_g unchanged after short frame", int'(gain_g), 'h2A);
            frame(1'b0, 3, 'h01, 5, 17, v);
            rd_chk("R6 long frame discarded", 3);
            frame(1'b0, 6, 'h1C3, 5, 4, v);
            rd_chk("R6 header-only frame discarded", 6);
        end

        // R7: power-down retains everything
        wr(0, 'h07C);
        chk("R7 power_down set", int'(power_down), 1);
        for (int a = 1; a < 8; a++) rd_chk("R7 retained under power-down", a);
        wr(5, 'h1AB);
        rd_chk("R7 writable under power-down", 5);
        rd_chk("R7 mode word under power-down", 0);
        wr(0, 'h078);
        chk("R7 power_down cleared", int'(power_down), 0);

        // R8: field mapping and sign-magnitude offsets
        wr(5, 'h100);
        chk("R8 offset_r negative zero", int'(offset_r), 'h100);
        wr(7, 'h0FF);
        chk("R8 offset_b max positive", int'(offset_b), 'h0FF);
        wr(1, 'h020);
        chk("R8 single_g select", int'(single_g), 1);
        chk("R8 order blue first", int'(order_rgb), 0);
        wr(0, 'h080);
        chk("R8 fs_range_hi", int'(fs_range_hi), 1);
        chk("R8 cds_en off", int'(cds_en), 0);

        // R4: reset again restores defaults
        cmp_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cmp_on = 1'b1;
        chk("R4 three_ch_en after reset", int'(three_ch_en), 1);
        rd_chk("R4 mode word after reset", 0);
        rd_chk("R4 offset after reset", 7);

        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule